// File: doc/BRIEF.md
# Infrared Pulse Codec

This block is the infrared modulation stage placed between a UART serialiser and an optical transceiver. On the transmit side it samples the NRZ line once per bit. It turns every zero bit into a short high pulse centred in the bit period. A one bit, like an idle line, leaves the optical output low. On the receive side it watches the photodiode line at each oversampling tick and rebuilds the NRZ stream. Any bit period in which a pulse was seen becomes a zero.

All timing comes from a single 16x bit-rate clock enable. A mode bit selects the pulse width. Standard mode, the reset default, is meant for rates up to 115.2 kbps and uses a pulse of 3/16 of a bit. Fast mode is meant for rates up to 1.152 Mbps and uses a pulse of 1/4 of a bit. The mode bit is written through a strobe that takes effect only while the enhanced-feature unlock input is high. When infrared operation is switched off, both directions pass straight through.

Top module: `irda_codec`

## Requirements
- R1: With `ir_on`=1 and `fast_mode`=0, a latched zero bit drives `ir_tx` high exactly while the bit phase is 7, 8 or 9 (a 3-tick pulse).
- R2: With `ir_on`=1 and `fast_mode`=1, a latched zero bit drives `ir_tx` high exactly while the bit phase is 6, 7, 8 or 9 (a 4-tick pulse).
- R3: The bit phase is 0 after reset and advances by one on each cycle with `tick16`=1, wrapping from 15 to 0. On a tick at phase 15, `tx_nrz` is latched as the bit for the next 16 ticks. After reset the latched bit is 1.
- R4: While the latched bit is 1 (a one bit or an idle line), `ir_tx` stays low for the whole bit when `ir_on`=1.
- R5: `fast_mode` is 0 after reset. A cycle with `mode_wr`=1 and `feat_unlock`=1 loads `mode_wdata` into it. A cycle with `mode_wr`=1 and `feat_unlock`=0 leaves it unchanged.
- R6: With `ir_on`=1, on a tick at phase 15 `rx_nrz` becomes 0 if `ir_rx` was 1 on any tick of that bit (phases 0 to 15), and 1 otherwise. It then holds that value until the next tick at phase 15. After reset it is 1.
- R7: With `ir_on`=0, `ir_tx` equals `tx_nrz` and `rx_nrz` equals `ir_rx` in the same cycle.
- R8: A high level on `ir_rx` only in cycles with `tick16`=0 is not a pulse and leaves the decoded bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | 16x bit-rate clock enable |
| ir_on | input | 1 | 1 = infrared coding, 0 = pass-through |
| feat_unlock | input | 1 | Enhanced-feature enable, gates mode writes |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 1 | Mode value to write (1 = fast) |
| tx_nrz | input | 1 | NRZ transmit data from the serialiser |
| ir_tx | output | 1 | Pulse output to the transceiver |
| ir_rx | input | 1 | Pulse input from the transceiver, high = light |
| rx_nrz | output | 1 | Rebuilt NRZ receive data |
| fast_mode | output | 1 | Current mode bit (0 = 3/16, 1 = 1/4) |

## Verification
On every cycle the assertions check the following. The phase wraps to 0 after its last tick. The latched transmit bit and the decoded receive bit change only at a bit boundary. A blocked mode write leaves the mode unchanged. No pulse leaves the encoder outside phases 6 to 9. The exact pulse position for each mode, the any-tick-high rule of the decoder, the rejection of high levels between ticks, and pass-through are shown by the bench. It compares both outputs each cycle against its own model under random tick spacing, data, mode writes and enable changes, plus directed cases.

// File: rtl/irda_pkg.sv
package irda_pkg;
  // True when phase ph lies inside the pulse window for the given mode.
  // The window ends one tick past mid-bit; its width is 3/16 or 1/4 of a bit.
  function automatic logic pulse_on(input int unsigned ph, input logic fast,
                                    input int unsigned osr);
    int unsigned width;
    int unsigned last;
    int unsigned first;
    width = fast ? (osr / 4) : ((3 * osr) / 16);
    last  = (osr / 2) + 1;
    first = last + 1 - width;
    return (ph >= first) && (ph <= last);
  endfunction
endpackage

// File: rtl/irda_phase.sv
module irda_phase #(
  parameter int unsigned OSR  = 16,
  localparam int unsigned PH_W = $clog2(OSR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic [PH_W-1:0] ph,
  output logic            bit_end
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

  assign bit_end = tick && (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph <= '0;
    else if (bit_end) ph <= '0;
    else if (tick)    ph <= ph + 1'b1;
  end

  a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (ph == '0));
  a_r3_phase_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ph));
endmodule

// File: rtl/irda_tx_enc.sv
module irda_tx_enc #(
  parameter int unsigned OSR  = 16,
  localparam int unsigned PH_W = $clog2(OSR)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_end,
  input  logic [PH_W-1:0] ph,
  input  logic            fast,
  input  logic            tx_nrz,
  output logic            pulse
);
  import irda_pkg::*;

  logic held;  // bit being sent during the current period

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= 1'b1;
    else if (bit_end) held <= tx_nrz;
  end

  assign pulse = !held && pulse_on(int'(ph), fast, OSR);

  a_r3_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_end |=> $stable(held));
  // R1, R2: no mode ever pulses outside phases 6..9
  a_r2_window: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (int'(ph) >= (OSR/2 - 2)) && (int'(ph) <= (OSR/2 + 1)));
endmodule

// File: rtl/irda_rx_dec.sv
module irda_rx_dec (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bit_end,
  input  logic ir_rx,
  output logic rx_bit
);
  logic seen;  // a high sample was taken earlier in this bit

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen   <= 1'b0;
      rx_bit <= 1'b1;
    end else if (bit_end) begin
      rx_bit <= !(seen || ir_rx);
      seen   <= 1'b0;
    end else if (tick) begin
      seen   <= seen || ir_rx;
    end
  end

  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_end |=> $stable(rx_bit));
  a_r8_no_tick_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !seen) |=> !seen);
endmodule

// File: rtl/irda_codec.sv
module irda_codec #(
  parameter int unsigned OSR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick16,
  input  logic ir_on,
  input  logic feat_unlock,
  input  logic mode_wr,
  input  logic mode_wdata,
  input  logic tx_nrz,
  output logic ir_tx,
  input  logic ir_rx,
  output logic rx_nrz,
  output logic fast_mode
);
  localparam int unsigned PH_W = $clog2(OSR);

  logic [PH_W-1:0] ph;
  logic            bit_end;
  logic            enc_pulse;
  logic            dec_bit;
  logic            mode_load;

  assign mode_load = mode_wr && feat_unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fast_mode <= 1'b0;
    else if (mode_load) fast_mode <= mode_wdata;
  end

  irda_phase #(.OSR(OSR)) u_phase (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .ph(ph), .bit_end(bit_end)
  );

  irda_tx_enc #(.OSR(OSR)) u_tx (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .ph(ph),
    .fast(fast_mode), .tx_nrz(tx_nrz), .pulse(enc_pulse)
  );

  irda_rx_dec u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .bit_end(bit_end),
    .ir_rx(ir_rx), .rx_bit(dec_bit)
  );

  assign ir_tx  = ir_on ? enc_pulse : tx_nrz;
  assign rx_nrz = ir_on ? dec_bit   : ir_rx;

  a_r5_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !feat_unlock) |=> $stable(fast_mode));
  a_r5_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && feat_unlock) |=> (fast_mode == $past(mode_wdata)));
endmodule

// File: tb/irda_codec_bench.sv
module irda_codec_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0, ir_on = 1'b1, feat_unlock = 1'b0;
  logic mode_wr = 1'b0, mode_wdata = 1'b0, tx_nrz = 1'b1, ir_rx = 1'b0;
  logic ir_tx, rx_nrz, fast_mode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model
  int   m_ph = 0;
  logic m_held = 1'b1, m_seen = 1'b0, m_rx = 1'b1, m_fast = 1'b0;

  always #10 clk = ~clk;

  irda_codec u_irda_codec (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .ir_on(ir_on),
    .feat_unlock(feat_unlock), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .tx_nrz(tx_nrz), .ir_tx(ir_tx), .ir_rx(ir_rx), .rx_nrz(rx_nrz),
    .fast_mode(fast_mode)
  );

  function automatic logic exp_window(int ph, logic fast);
    if (ph == 6) return fast;
    return (ph > 6) && (ph < 10);
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (phase %0d)", req, act, exp, m_ph);
    end
  endtask

  // one clock: inputs already set; update model at edge, check at negedge
  task automatic step();
    @(posedge clk);
    if (mode_wr && feat_unlock) m_fast = mode_wdata;
    if (tick16) begin
      if (m_ph == 15) begin
        m_held = tx_nrz;
        m_rx   = !(m_seen || ir_rx);
        m_seen = 1'b0;
        m_ph   = 0;
      end else begin
        if (ir_rx) m_seen = 1'b1;
        m_ph++;
      end
    end
    @(negedge clk);
    check("R5", fast_mode, m_fast);
    if (!ir_on) begin
      check("R7", ir_tx, tx_nrz);
      check("R7", rx_nrz, ir_rx);
    end else begin
      if (m_held) check("R4", ir_tx, 1'b0);
      else if (m_fast) check("R2", ir_tx, exp_window(m_ph, 1'b1));
      else check("R1", ir_tx, exp_window(m_ph, 1'b0));
      check("R6", rx_nrz, m_rx);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R3", ir_tx, 1'b0);   // reset: held bit 1, IR on, no pulse
    check("R6", rx_nrz, 1'b1);
    check("R5", fast_mode, 1'b0);
    rst_n = 1'b1;

    // directed R1: standard mode, zero bit, tick every cycle
    tick16 = 1'b1; tx_nrz = 1'b0;
    repeat (48) step();
    // directed R5: blocked write then allowed write, then R2 pulses
    mode_wr = 1'b1; mode_wdata = 1'b1; feat_unlock = 1'b0;
    step();
    check("R5", fast_mode, 1'b0);
    feat_unlock = 1'b1;
    step();
    check("R5", fast_mode, 1'b1);
    mode_wr = 1'b0; feat_unlock = 1'b0;
    repeat (40) step();
    // directed R8: rx high only between ticks for two full bits
    tx_nrz = 1'b1;
    for (int i = 0; i < 80; i++) begin
      tick16 = i[0];
      ir_rx  = !i[0];
      step();
    end
    ir_rx = 1'b0; tick16 = 1'b0;
    check("R8", rx_nrz, 1'b1);
    step();

    // random phase
    for (int i = 0; i < 6000; i++) begin
      tick16      = ($urandom % 3) != 0;
      tx_nrz      = ($urandom % 2) != 0;
      ir_rx       = ($urandom % 10) == 0;
      mode_wr     = ($urandom % 50) == 0;
      mode_wdata  = ($urandom % 2) != 0;
      feat_unlock = ($urandom % 2) != 0;
      if (($urandom % 200) == 0) ir_on = !ir_on;
      step();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule